// File: doc/BRIEF.md
# Direct-Sequence BPSK Chip Spreader

This block produces a direct-sequence spread-spectrum signal with binary phase shift keying, in the form of wide parallel words meant for a downstream serializer or parallel DAC. A pseudo-random chip sequence sits in a small internal table. The block steps through that table at the chip rate and XORs each chip with the data bit currently being sent. The result picks one of two carrier words. Each word is an alternating bit pattern, and the two words are 180 degrees apart in phase. Once the word is shifted out LSB first at the serial clock, the carrier sits at half that clock. For example, an 80 MHz serializer gives a 40 MHz carrier, and 32-bit words give a 2.5 MHz chip rate.

One data bit covers the whole chip sequence. The data bit is inverted in the sense that a 1 flips every chip of that period. The block asks for the next bit with a one-cycle request pulse at the moment the sequence wraps. A typical source rotates a fixed 32-bit data word MSB first, so the modulated stream repeats every 32 data bits. The table is loaded through a simple write port while the block is stopped. A balanced table, with equal counts of ones and zeros, keeps the spectrum free of a residual carrier.

Top module: `dsss_chip_spreader`

## Requirements
- R1: After reset `pat_valid` and `data_ready` are 0 and `pat_out` is 0. The chip index restarts at 0 and the held data bit is 0, so the first sequence pass after reset is sent unmodulated.
- R2: While `enable` is high, `pat_valid` pulses for one cycle exactly once every CHIP_PERIOD enabled clock cycles. The first pulse comes CHIP_PERIOD enabled cycles after reset.
- R3: Every strobed word is one of two carrier words. A sent chip of 1 gives ones on odd bit positions only (0xAAAAAAAA for 32 bits). A sent chip of 0 gives ones on even positions only (0x55555555).
- R4: Chip number n of the sequence is bit WORD_W-1-(n mod WORD_W) of table word n/WORD_W, so each word is used MSB first. The index advances by one per strobe and wraps from the last chip back to 0.
- R5: The sent chip equals the table chip XOR the held data bit. A data bit of 1 inverts the whole sequence for that data period.
- R6: `data_ready` is high only during the cycle whose closing edge emits the last chip of the sequence. `data_in` is sampled at that edge and applies from chip 0 onward, and the strobe carrying the last chip follows in the next cycle.
- R7: While `enable` is low no strobe and no `data_ready` occur and `pat_out` holds its value. The chip timer and index are kept, so resuming continues the sequence where it stopped.
- R8: A table write (`tbl_we`) is accepted only while `enable` is low. A write presented while `enable` is high leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the chip timer; low freezes the block and opens the table port |
| data_in | input | 1 | Next data bit, sampled at the sequence wrap |
| data_ready | output | 1 | High in the cycle whose edge samples `data_in` |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | $clog2(TABLE_WORDS) | Table word address |
| tbl_wdata | input | WORD_W | Table word, first chip in the MSB |
| pat_out | output | PAT_W | Carrier word for the serializer, shifted out LSB first |
| pat_valid | output | 1 | One-cycle strobe per chip marking a new `pat_out` |

## Verification
A chip tick is an enabled edge on which the timer reaches CHIP_PERIOD-1. The word and strobe for that tick appear one cycle later. `data_ready` is combinational in the cycle just before the tick edge, so the bench sees it one clock ahead of the strobe that carries the last chip. The bench samples every output at the falling edge. When it sees `data_ready`, it leaves `data_in` untouched through the next rising edge. Only after that edge does it move to the next data bit, and it applies that bit to expected strobes from then on. Strobe spacing is counted only over edges where `enable` was high. The hold check compares `pat_out` with the last value seen before `enable` fell.

// File: rtl/dsss_spreader_pkg.sv
package dsss_spreader_pkg;

  // Bit at position pos of the carrier word for a given sent chip:
  // chip 1 -> ones on odd positions, chip 0 -> ones on even positions.
  function automatic logic carrier_bit(input logic chip, input int pos);
    return chip ^ ((pos % 2) == 0);
  endfunction

  // Chip put on the air: sequence chip modulated by the data bit.
  function automatic logic sent_chip(input logic seq_chip, input logic data_bit);
    return seq_chip ^ data_bit;
  endfunction

endpackage

// File: rtl/dsss_chip_table.sv
module dsss_chip_table #(
  parameter int WORD_W      = 32,
  parameter int TABLE_WORDS = 32,
  localparam int AW = $clog2(TABLE_WORDS),
  localparam int BW = $clog2(WORD_W),
  localparam int IW = AW + BW
) (
  input  logic              clk,
  input  logic              enable,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IW-1:0]     chip_idx,
  output logic              chip_raw,
  output logic              wr_accept
);

  logic [WORD_W-1:0] words [TABLE_WORDS];
  logic [WORD_W-1:0] cur_word;

  // Writes only land while the spreader is stopped.
  assign wr_accept = wr_en && !enable;

  always_ff @(posedge clk) begin
    if (wr_accept) words[wr_addr] <= wr_data;
  end

  // Upper index bits pick the word, lower bits pick the chip, MSB first.
  assign cur_word = words[chip_idx[IW-1:BW]];
  assign chip_raw = cur_word[~chip_idx[BW-1:0]];

endmodule

// File: rtl/dsss_chip_sequencer.sv
module dsss_chip_sequencer #(
  parameter int WORD_W      = 32,
  parameter int TABLE_WORDS = 32,
  parameter int CHIP_PERIOD = 32,
  localparam int IW = $clog2(TABLE_WORDS) + $clog2(WORD_W),
  localparam int TW = (CHIP_PERIOD > 1) ? $clog2(CHIP_PERIOD) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          data_in,
  output logic          chip_tick,
  output logic          seq_wrap,
  output logic [IW-1:0] chip_idx,
  output logic          cur_bit
);

  localparam logic [TW-1:0] TIMER_LAST = TW'(CHIP_PERIOD - 1);
  localparam logic [IW-1:0] IDX_LAST   = IW'(TABLE_WORDS * WORD_W - 1);

  logic [TW-1:0] timer_q;
  logic          at_last_chip;

  assign chip_tick    = enable && (timer_q == TIMER_LAST);
  assign at_last_chip = (chip_idx == IDX_LAST);
  assign seq_wrap     = chip_tick && at_last_chip;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer_q  <= '0;
      chip_idx <= '0;
      cur_bit  <= 1'b0;
    end else if (enable) begin
      timer_q <= chip_tick ? '0 : timer_q + 1'b1;
      if (chip_tick) begin
        chip_idx <= at_last_chip ? '0 : chip_idx + 1'b1;
        if (at_last_chip) cur_bit <= data_in;
      end
    end
  end

endmodule

// File: rtl/dsss_carrier_mapper.sv
module dsss_carrier_mapper
  import dsss_spreader_pkg::*;
#(
  parameter int PAT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_tick,
  input  logic             chip_raw,
  input  logic             cur_bit,
  output logic [PAT_W-1:0] pat_out,
  output logic             pat_valid
);

  logic             chip_tx;
  logic [PAT_W-1:0] word_d;

  assign chip_tx = sent_chip(chip_raw, cur_bit);

  always_comb begin
    for (int i = 0; i < PAT_W; i++) word_d[i] = carrier_bit(chip_tx, i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pat_out   <= '0;
      pat_valid <= 1'b0;
    end else begin
      pat_valid <= chip_tick;
      if (chip_tick) pat_out <= word_d;
    end
  end

endmodule

// File: rtl/dsss_chip_spreader.sv
module dsss_chip_spreader #(
  parameter int PAT_W       = 32,
  parameter int WORD_W      = 32,
  parameter int TABLE_WORDS = 32,
  parameter int CHIP_PERIOD = 32,
  localparam int AW = $clog2(TABLE_WORDS),
  localparam int IW = AW + $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              data_in,
  output logic              data_ready,
  input  logic              tbl_we,
  input  logic [AW-1:0]     tbl_addr,
  input  logic [WORD_W-1:0] tbl_wdata,
  output logic [PAT_W-1:0]  pat_out,
  output logic              pat_valid
);

  logic          chip_tick;
  logic          seq_wrap;
  logic [IW-1:0] chip_idx;
  logic          cur_bit;
  logic          chip_raw;
  logic          wr_accept;

  dsss_chip_sequencer #(
    .WORD_W(WORD_W), .TABLE_WORDS(TABLE_WORDS), .CHIP_PERIOD(CHIP_PERIOD)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .data_in(data_in),
    .chip_tick(chip_tick), .seq_wrap(seq_wrap), .chip_idx(chip_idx),
    .cur_bit(cur_bit)
  );

  dsss_chip_table #(
    .WORD_W(WORD_W), .TABLE_WORDS(TABLE_WORDS)
  ) u_table (
    .clk(clk), .enable(enable), .wr_en(tbl_we), .wr_addr(tbl_addr),
    .wr_data(tbl_wdata), .chip_idx(chip_idx), .chip_raw(chip_raw),
    .wr_accept(wr_accept)
  );

  dsss_carrier_mapper #(
    .PAT_W(PAT_W)
  ) u_map (
    .clk(clk), .rst_n(rst_n), .chip_tick(chip_tick), .chip_raw(chip_raw),
    .cur_bit(cur_bit), .pat_out(pat_out), .pat_valid(pat_valid)
  );

  assign data_ready = seq_wrap;

endmodule

// File: rtl/dsss_spreader_checker.sv
module dsss_spreader_checker
  import dsss_spreader_pkg::*;
#(
  parameter int PAT_W       = 32,
  parameter int CHIP_PERIOD = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             pat_valid,
  input logic [PAT_W-1:0] pat_out,
  input logic             data_ready,
  input logic             chip_tick,
  input logic             chip_raw,
  input logic             cur_bit,
  input logic             wr_accept
);

  logic [PAT_W-1:0] word_one;
  logic [PAT_W-1:0] word_zero;
  logic [31:0]      gap_q;

  always_comb begin
    for (int i = 0; i < PAT_W; i++) begin
      word_one[i]  = carrier_bit(1'b1, i);
      word_zero[i] = carrier_bit(1'b0, i);
    end
  end

  // Enabled edges since the last strobe (or since reset).
  always_ff @(posedge clk) begin
    if (!rst_n)         gap_q <= '0;
    else if (pat_valid) gap_q <= enable ? 32'd1 : 32'd0;
    else if (enable)    gap_q <= gap_q + 32'd1;
  end

  p_strobe_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pat_valid |-> (gap_q == 32'(CHIP_PERIOD)));

  p_carrier_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pat_valid |-> (pat_out == word_one || pat_out == word_zero));

  p_chip_xor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chip_tick |=> (pat_out == (($past(chip_raw) ^ $past(cur_bit)) ? word_one : word_zero)));

  p_ready_then_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |=> pat_valid);

  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!pat_valid && $stable(pat_out)));

  p_no_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !data_ready);

  p_write_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> !wr_accept);

endmodule

bind dsss_chip_spreader dsss_spreader_checker #(
  .PAT_W(PAT_W), .CHIP_PERIOD(CHIP_PERIOD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .pat_valid(pat_valid),
  .pat_out(pat_out), .data_ready(data_ready), .chip_tick(chip_tick),
  .chip_raw(chip_raw), .cur_bit(cur_bit), .wr_accept(wr_accept)
);

// File: tb/dsss_chip_spreader_bench.sv
module dsss_chip_spreader_bench;

  localparam int PAT_W = 32;
  localparam int WW    = 8;
  localparam int TWDS  = 4;
  localparam int PER   = 3;
  localparam int NCH   = WW * TWDS;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic             data_in = 1'b0;
  logic             data_ready;
  logic             tbl_we = 1'b0;
  logic [1:0]       tbl_addr = '0;
  logic [WW-1:0]    tbl_wdata = '0;
  logic [PAT_W-1:0] pat_out;
  logic             pat_valid;

  always #2 clk = ~clk;

  dsss_chip_spreader #(
    .PAT_W(PAT_W), .WORD_W(WW), .TABLE_WORDS(TWDS), .CHIP_PERIOD(PER)
  ) u_dsss_chip_spreader (
    .clk(clk), .rst_n(rst_n), .enable(enable), .data_in(data_in),
    .data_ready(data_ready), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .pat_out(pat_out), .pat_valid(pat_valid)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [WW-1:0] tbl [TWDS];
  logic [31:0] dword = 32'h9E37_4C1B;
  int ptr = 0;
  int k = 0;
  int gap = 0;
  logic exp_bit = 1'b0;
  logic pend = 1'b0;
  logic want_strobe = 1'b0;
  logic [PAT_W-1:0] held = '0;

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    logic en_edge;
    int idx;
    logic c;
    @(negedge clk);
    en_edge = enable;
    if (en_edge) gap++;
    if (want_strobe) begin
      check(pat_valid, "R6 strobe after ready", {31'd0, pat_valid}, 32'd1);
      want_strobe = 1'b0;
    end
    if (!en_edge) begin
      check(!pat_valid && !data_ready && pat_out == held, "R7 frozen",
            pat_out, held);
    end
    if (pat_valid) begin
      check(gap == PER, "R2 strobe spacing", gap, PER);
      gap = 0;
      idx = k % NCH;
      c = tbl[idx / WW][WW - 1 - (idx % WW)] ^ exp_bit;
      check(pat_out == (c ? 32'hAAAA_AAAA : 32'h5555_5555),
            "R3/R4/R5 carrier word", pat_out, c ? 32'hAAAA_AAAA : 32'h5555_5555);
      k++;
    end
    held = pat_out;
    if (pend) begin
      exp_bit = data_in;
      ptr++;
      data_in = dword[31 - (ptr % 32)];
      pend = 1'b0;
    end
    if (data_ready) begin
      check((k % NCH) == NCH - 1, "R6 ready at last chip", k % NCH, NCH - 1);
      pend = 1'b1;
      want_strobe = 1'b1;
    end
  endtask

  initial begin
    tbl[0] = 8'hB4; tbl[1] = 8'h3C; tbl[2] = 8'h69; tbl[3] = 8'hD2;
    data_in = dword[31];
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!pat_valid && !data_ready && pat_out == '0, "R1 reset state",
          pat_out, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < TWDS; i++) begin
      tbl_we = 1'b1; tbl_addr = 2'(i); tbl_wdata = tbl[i];
      @(negedge clk);
    end
    tbl_we = 1'b0;
    check(!pat_valid, "R1 idle before enable", {31'd0, pat_valid}, 32'd0);
    enable = 1'b1;
    for (int i = 0; i < 3600; i++) begin
      step();
      if (i == 700) begin
        tbl_we = 1'b1; tbl_addr = 2'd0; tbl_wdata = 8'h00;   // R8: must be ignored
      end
      if (i == 701) tbl_we = 1'b0;
      if (i == 1000) enable = 1'b0;
      if (i == 1004) begin
        tbl_we = 1'b1; tbl_addr = 2'd1; tbl_wdata = 8'h5A;   // R8: accepted while stopped
        tbl[1] = 8'h5A;
      end
      if (i == 1005) tbl_we = 1'b0;
      if (i == 1012) enable = 1'b1;
    end
    check(k > 1000, "R2 strobes produced", k, 1000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule